// File: doc/BRIEF.md
# Model-Specific-Register Permission Bitmap Checker

When a guest touches a model-specific register and that class of access is intercepted, this block decides whether the access must leave the guest. The register index is folded into a single permission bitmap held in memory. Three disjoint index windows share this bitmap, each at its own slot offset, and each register owns two bits in it. The block turns the index into a byte address and a bit number. It fetches that one byte through a simple request/valid read port and reports exit when the selected bit is 1.

An index that lies in none of the windows is refused at once: the block raises exit without touching memory. The block handles one check at a time. A start strobe that arrives while a check is in flight is dropped. Each check ends with a one-cycle done pulse, and the exit flag is valid in that same cycle.

Top module: `msr_perm_check`

## Requirements
- R1: Register slot s owns bitmap bits 2s and 2s+1. The read bit is 2s (wr_i=0) and the write bit is 2s+1 (wr_i=1). Inside the fetched byte, the bit tested is (2s mod 8) plus wr_i.
- R2: Indices 0x00000000 through 0x00001FFF use slot s = index.
- R3: Indices 0xC0000000 through 0xC0001FFF use slot s = 8192 + (index - 0xC0000000).
- R4: Indices 0xC0010000 through 0xC0011FFF use slot s = 16384 + (index - 0xC0010000).
- R5: The read address is rd_addr_o = base_i + floor(2s / 8). It is held while rd_req_o is high.
- R6: For an index outside all three windows, done_o and exit_o are both 1 in the cycle after start is accepted, and no read is issued.
- R7: For an index inside a window, exit_o equals the selected bit of rd_data_i, taken in the cycle in which rd_valid_i is high.
- R8: A check issues at most one read. rd_req_o is high for exactly one cycle. start_i is ignored from the cycle after acceptance until done_o has fallen.
- R9: done_o is high for exactly one cycle per check. exit_o is 0 whenever done_o is 0. Both outputs, and rd_req_o, are 0 during reset.
- R10: rd_req_o rises in the cycle after start is accepted. done_o rises in the cycle after the cycle in which rd_valid_i is seen high while a response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a check (accepted only when idle) |
| idx_i | input | IDX_W | Register index |
| wr_i | input | 1 | Direction: 0 read, 1 write |
| base_i | input | ADDR_W | Bitmap base byte address |
| rd_req_o | output | 1 | One-byte read request |
| rd_addr_o | output | ADDR_W | Byte address of the read |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Fetched bitmap byte |
| done_o | output | 1 | Check complete, one cycle |
| exit_o | output | 1 | Access must exit (valid with done_o) |

## Verification
The bench builds the block with its default parameters: 32-bit indices, 48-bit addresses, three windows of 8192 registers, and a 16-bit bit position. With these values both edges of every window can be reached. That includes the highest bitmap byte, 6143, and the indices that lie one step outside each window, where a fetch must not occur. The response latency is varied from one to four cycles. A second start is injected while a fetch is pending, to show that the first check keeps its result and issues only one read.

// File: rtl/msr_perm_pkg.sv
package msr_perm_pkg;
  localparam int unsigned NUM_WIN  = 3;
  localparam int unsigned WIN_SPAN = 8192;
  // window order fixes slot offset: window w starts at slot w*WIN_SPAN
  localparam logic [31:0] WIN_START [NUM_WIN] = '{32'h0000_0000, 32'hC000_0000, 32'hC001_0000};

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } chk_state_e;
endpackage

// File: rtl/msr_win_decode.sv
module msr_win_decode
  import msr_perm_pkg::*;
#(
  parameter int unsigned IDX_W    = 32,
  parameter int unsigned SPAN     = WIN_SPAN,
  parameter int unsigned POS_W    = $clog2(NUM_WIN * SPAN * 2)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             hit_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int unsigned SPAN_W = $clog2(SPAN);

  logic [NUM_WIN-1:0]            hit_w;
  logic [NUM_WIN-1:0][POS_W-1:0] pos_w;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [IDX_W-1:0] rel;
    logic [POS_W-1:0] slot;
    assign rel        = idx_i - IDX_W'(WIN_START[g]);
    assign hit_w[g]   = rel < IDX_W'(SPAN);
    assign slot       = POS_W'(g * SPAN) + POS_W'(rel[SPAN_W-1:0]);
    assign pos_w[g]   = {slot[POS_W-2:0], 1'b0};
  end

  always_comb begin
    pos_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (hit_w[w]) pos_o = pos_o | pos_w[w];
    end
    hit_o = |hit_w;
  end
endmodule

// File: rtl/msr_bit_pick.sv
module msr_bit_pick (
  input  logic [7:0] byte_i,
  input  logic [2:0] sel_i,
  output logic       bit_o
);
  assign bit_o = byte_i[sel_i];
endmodule

// File: rtl/msr_perm_check.sv
module msr_perm_check
  import msr_perm_pkg::*;
#(
  parameter int unsigned IDX_W  = 32,
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned SPAN   = WIN_SPAN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_data_i,
  output logic              done_o,
  output logic              exit_o
);
  localparam int unsigned POS_W  = $clog2(NUM_WIN * SPAN * 2);
  localparam int unsigned BYTE_W = POS_W - 3;

  chk_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        sel_q;
  logic              exit_q;
  logic              win_hit;
  logic [POS_W-1:0]  win_pos;
  logic              bit_w;
  logic              busy;
  logic [BYTE_W-1:0] byte_off;

  msr_win_decode #(.IDX_W(IDX_W), .SPAN(SPAN), .POS_W(POS_W)) u_dec (
    .idx_i (idx_i),
    .hit_o (win_hit),
    .pos_o (win_pos)
  );

  msr_bit_pick u_pick (
    .byte_i (rd_data_i),
    .sel_i  (sel_q),
    .bit_o  (bit_w)
  );

  assign byte_off = win_pos[POS_W-1:3];
  assign busy     = state_q != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      sel_q   <= '0;
      exit_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (win_hit) begin
            addr_q  <= base_i + ADDR_W'(byte_off);
            sel_q   <= win_pos[2:0] + {2'b00, wr_i};
            exit_q  <= 1'b0;
            state_q <= ST_REQ;
          end else begin
            exit_q  <= 1'b1;  // no window: refuse without a fetch
            state_q <= ST_DONE;
          end
        end
        ST_REQ:  state_q <= ST_WAIT;
        ST_WAIT: if (rd_valid_i) begin
          exit_q  <= bit_w;
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          exit_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o  = state_q == ST_REQ;
  assign rd_addr_o = addr_q;
  assign done_o    = state_q == ST_DONE;
  assign exit_o    = exit_q;
endmodule

// File: rtl/msr_perm_check_sva.sv
module msr_perm_check_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_i,
  input logic hit_i,
  input logic rd_req_o,
  input logic done_o,
  input logic exit_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  // R6
  miss_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && !hit_i) |=> (done_o && exit_o && !rd_req_o));
  // R10
  req_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && hit_i) |=> rd_req_o);
  // R9
  exit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |-> done_o);
  // R8
  req_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !done_o);
endmodule

bind msr_perm_check msr_perm_check_sva u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_i   (busy),
  .hit_i    (win_hit),
  .rd_req_o (rd_req_o),
  .done_o   (done_o),
  .exit_o   (exit_o)
);

// File: tb/test_msr_perm_check.sv
`timescale 1ns/1ps
module test_msr_perm_check;
  localparam int ADDR_W = 48;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [31:0]       idx_i = '0;
  logic              wr_i = 1'b0;
  logic [ADDR_W-1:0] base_i = 48'h0000_1234_5000;
  logic              rd_req_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic              rd_valid_i = 1'b0;
  logic [7:0]        rd_data_i = '0;
  logic              done_o;
  logic              exit_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  msr_perm_check #(.ADDR_W(ADDR_W)) i_msr_perm_check (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .idx_i(idx_i), .wr_i(wr_i),
    .base_i(base_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .done_o(done_o), .exit_o(exit_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic longint slot_of(input logic [31:0] idx);
    longint v = longint'(idx);
    if (v <= 64'h1FFF) return v;
    if (v >= 64'hC000_0000 && v <= 64'hC000_1FFF) return 8192 + v - 64'hC000_0000;
    if (v >= 64'hC001_0000 && v <= 64'hC001_1FFF) return 16384 + v - 64'hC001_0000;
    return -1;
  endfunction

  // behavioural reference, one step per clock
  int          m_phase = 0;
  longint      m_addr = 0;
  int          m_bit = 0;
  bit          m_exit = 0;

  always @(posedge clk or negedge rst_ni) begin
    longint s;
    if (!rst_ni) begin
      m_phase <= 0;
      m_exit  <= 0;
    end else begin
      case (m_phase)
        0: if (start_i) begin
          s = slot_of(idx_i);
          if (s < 0) begin
            m_phase <= 3;
            m_exit  <= 1;
          end else begin
            m_phase <= 1;
            m_addr  <= longint'(base_i) + (s * 2) / 8;
            m_bit   <= int'((s * 2) % 8) + int'(wr_i);
            m_exit  <= 0;
          end
        end
        1: m_phase <= 2;
        2: if (rd_valid_i) begin
          m_phase <= 3;
          m_exit  <= rd_data_i[m_bit];
        end
        default: begin
          m_phase <= 0;
          m_exit  <= 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      chk(rd_req_o == (m_phase == 1), "R10", "rd_req_o", rd_req_o, m_phase == 1);
      chk(done_o == (m_phase == 3), "R9", "done_o", done_o, m_phase == 3);
      chk(exit_o == m_exit, "R7", "exit_o", exit_o, m_exit);
      if (rd_req_o) chk(longint'(rd_addr_o) == m_addr, "R5", "rd_addr_o", rd_addr_o, m_addr);
    end
  end

  // memory responder
  int          lat_v = 1;
  int          pend = 0;
  int          req_cnt = 0;
  logic [7:0]  mem_byte = '0;
  longint      last_addr = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      rd_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rd_valid_i = 1'b1;
          rd_data_i  = mem_byte;
        end
      end
      if (rd_req_o) begin
        req_cnt++;
        last_addr = longint'(rd_addr_o);
        pend = lat_v;
      end
    end
  end

  task automatic run(input logic [31:0] idx, input bit wr, input logic [7:0] data,
                     input int lat, input string req, input bit exp_exit,
                     input bit exp_read, input longint exp_off,
                     input bit noise = 0);
    int n = 0;
    mem_byte = data;
    lat_v    = lat;
    req_cnt  = 0;
    @(negedge clk);
    start_i = 1'b1; idx_i = idx; wr_i = wr;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && n < 60) begin
      start_i = noise && (n == 1);
      if (noise) idx_i = 32'hFFFF_FFFF;
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    chk(n < 60, req, "done reached", n, 60);
    chk(exit_o == exp_exit, req, "exit at done", exit_o, exp_exit);
    chk(req_cnt == int'(exp_read), "R8", "read count", req_cnt, exp_read);
    if (exp_read)
      chk(last_addr == longint'(base_i) + exp_off, req, "byte address",
          last_addr, longint'(base_i) + exp_off);
    @(negedge clk);
    chk(!done_o && !exit_o, "R9", "done single cycle", done_o, 0);
  endtask

  initial begin
    #12;
    chk(!rd_req_o && !done_o && !exit_o, "R9", "reset outputs", {rd_req_o, done_o, exit_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R2 R1: read bit of index 0
    run(32'h0000_0000, 0, 8'h01, 1, "R2", 1, 1, 0);
    // R1: write bit sits at odd position
    run(32'h0000_0000, 1, 8'h01, 1, "R1", 0, 1, 0);
    // R2: top of first window, bit 7 of byte 0x7FF
    run(32'h0000_1FFF, 1, 8'h80, 2, "R2", 1, 1, 64'h7FF);
    // R6: one past first window
    run(32'h0000_2000, 0, 8'h00, 1, "R6", 1, 0, 0);
    // R3: base of second window, byte 2048 bit 0
    run(32'hC000_0000, 0, 8'hFE, 1, "R3", 0, 1, 64'd2048);
    // R3: top of second window, byte 4095 bit 6
    run(32'hC000_1FFF, 0, 8'h40, 3, "R3", 1, 1, 64'd4095);
    // R6: gap after second window
    run(32'hC000_2000, 1, 8'hFF, 1, "R6", 1, 0, 0);
    // R4: base of third window, byte 4096 bit 1
    run(32'hC001_0000, 1, 8'h02, 1, "R4", 1, 1, 64'd4096);
    // R4: top of third window, byte 6143 bit 7
    run(32'hC001_1FFF, 1, 8'h7F, 2, "R4", 0, 1, 64'd6143);
    // R6: just below second window, just below third, and all ones
    run(32'hBFFF_FFFF, 0, 8'h00, 1, "R6", 1, 0, 0);
    run(32'hC000_FFFF, 0, 8'h00, 1, "R6", 1, 0, 0);
    run(32'hFFFF_FFFF, 1, 8'h00, 1, "R6", 1, 0, 0);
    // R10 R1: long latency, slot 5 write bit -> byte 1 bit 3
    run(32'h0000_0005, 1, 8'h08, 4, "R10", 1, 1, 64'd1);
    // R8: a start while busy is dropped (noise index would force exit)
    run(32'h0000_0003, 0, 8'h00, 3, "R8", 0, 1, 0, 1);
    // R5: different base
    base_i = 48'hFFFF_FFFF_F000;
    run(32'h0000_1FFF, 0, 8'h40, 1, "R5", 1, 1, 64'h7FF);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule